// File: doc/BRIEF.md
# Voted Branch Clock Gate

This block gates a set of branch clocks and reports, for each branch, whether its clock is actually running. Software can turn a branch on in two ways. It can set the enable bit in that branch's own control word. It can also set that branch's bit in one of several shared vote words, each owned by a different requester. The branch clock enable is high whenever the local enable or any vote for that branch is set.

A status field in the upper nibble of each control word shows whether the clock is running. The field does not follow the request at once. Start-up and stop each take a fixed, parameterised number of cycles. The off flag at bit 31 therefore clears only once the clock is really running, which lets software enable a branch and then poll until the flag drops.

A branch can also be marked as run under fabric-controller management. While it runs, it then reports the alternate running code. Software is expected to read the status before voting and to skip the vote if the branch already runs. A vote cast on a running branch disturbs nothing.

Top module: `vclk_branch_gate`

## Requirements
- R1: After reset, every control word reads 0x8000_0000 (off flag set, status 0x8, enable 0), every vote word reads 0, and `clk_en_o` is all zero.
- R2: `clk_en_o[b]` is the OR of control bit 0 of branch b and bit b of every vote word. It changes on the same clock edge that accepts the write.
- R3: When branch b's effective enable rises and stays high, its status field (bits 31:28) changes from 0x8 to running exactly ON_LAT clock edges after the write edge. The running code is 0x0 when bit 1 is clear.
- R4: A running branch whose control bit 1 is set reports status 0x2 (only bit 29 set). The read-back word for that branch then includes bits 1 and 0.
- R5: When branch b's effective enable falls and stays low, its status returns to 0x8 exactly OFF_LAT clock edges after the write edge.
- R6: If the effective enable returns to its previous value before the latency elapses, the status never changes. A later change starts the full latency again.
- R7: Setting a vote bit for a branch that is already running leaves its status at running, with no off read in between.
- R8: In control writes, bits other than 0 and 1 are ignored, and bits 27:2 always read 0. In vote writes, bits at and above NUM_BRANCH are ignored and read 0.
- R9: A read returns its word on `bus_rdata` after the edge that accepts it. Control words sit at addresses 0 to NUM_BRANCH-1, and vote words follow at NUM_BRANCH onward. Unmapped addresses read 0, and writes to them change nothing.
- R10: Each vote word is independent. Clearing one requester's vote leaves a branch running while another vote or the local enable still holds it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held between reads |
| clk_en_o | output | NUM_BRANCH | Per-branch clock enable |

## Verification
The clock enable output is due on the edge that accepts the write, so it is compared at the following falling edge. Read data is registered and reflects the state just before the accepting edge. Because of that, a read issued on every cycle after an enable write sees exactly ON_LAT off readings before the first running one, and exactly OFF_LAT running readings after a disable. The bench counts those polls against the parameters. A behavioural model updated on every rising edge predicts the enable and read data, and both are compared at every falling edge.

// File: rtl/vcbg_pkg.sv
package vcbg_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned FSM_BIT  = 1;
  localparam int unsigned STAT_LSB = 28;

  typedef enum logic [3:0] {
    ST_ON     = 4'h0,
    ST_ON_FSM = 4'h2,
    ST_OFF    = 4'h8
  } stat_e;

  // status nibble reported for a branch
  function automatic stat_e status_code(input logic running, input logic fsm);
    if (!running)  return ST_OFF;
    else if (fsm)  return ST_ON_FSM;
    else           return ST_ON;
  endfunction

  // full control word as read back
  function automatic logic [WORD_W-1:0] ctrl_word(input logic running,
                                                  input logic fsm,
                                                  input logic en);
    logic [WORD_W-1:0] w;
    w = '0;
    w[STAT_LSB +: 4] = status_code(running, fsm);
    w[FSM_BIT]       = fsm;
    w[EN_BIT]        = en;
    return w;
  endfunction

  // width of a counter that counts 0 .. max_lat-1
  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > 1) ? $clog2(m) : 1;
  endfunction
endpackage

// File: rtl/vcbg_regs.sv
module vcbg_regs
  import vcbg_pkg::*;
#(
  parameter int unsigned NB     = 4,
  parameter int unsigned NV     = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [WORD_W-1:0]        wdata,
  output logic [NB-1:0]            en_o,
  output logic [NB-1:0]            fsm_o,
  output logic [NV-1:0][NB-1:0]    votes_o,
  output logic [NB-1:0]            req_o
);
  logic wr;
  assign wr = sel & we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o    <= '0;
      fsm_o   <= '0;
      votes_o <= '0;
    end else if (wr) begin
      for (int i = 0; i < NB; i++) begin
        if (addr == ADDR_W'(i)) begin
          en_o[i]  <= wdata[EN_BIT];
          fsm_o[i] <= wdata[FSM_BIT];
        end
      end
      for (int v = 0; v < NV; v++) begin
        if (addr == ADDR_W'(NB + v)) votes_o[v] <= wdata[NB-1:0];
      end
    end
  end

  // effective request: local enable OR any vote
  for (genvar b = 0; b < NB; b++) begin : g_req
    logic any_vote;
    always_comb begin
      any_vote = 1'b0;
      for (int v = 0; v < NV; v++) any_vote = any_vote | votes_o[v][b];
    end
    assign req_o[b] = en_o[b] | any_vote;
  end
endmodule

// File: rtl/vcbg_settle.sv
module vcbg_settle
  import vcbg_pkg::*;
#(
  parameter int unsigned ON_LAT  = 4,
  parameter int unsigned OFF_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic run,
  output logic start_evt,
  output logic stop_evt
);
  localparam int unsigned CNT_W = cnt_width(ON_LAT, OFF_LAT);
  localparam logic [CNT_W-1:0] ON_LIM  = CNT_W'(ON_LAT - 1);
  localparam logic [CNT_W-1:0] OFF_LIM = CNT_W'(OFF_LAT - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             differ;
  logic             expire;

  assign lim       = run ? OFF_LIM : ON_LIM;
  assign differ    = req ^ run;
  assign expire    = differ && (cnt == lim);
  assign start_evt = expire & req;
  assign stop_evt  = expire & ~req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (!differ) begin
      cnt <= '0;
    end else if (expire) begin
      cnt <= '0;
      run <= req;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vcbg_rdmux.sv
module vcbg_rdmux
  import vcbg_pkg::*;
#(
  parameter int unsigned NB     = 4,
  parameter int unsigned NV     = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NB-1:0]         en,
  input  logic [NB-1:0]         fsm,
  input  logic [NV-1:0][NB-1:0] votes,
  input  logic [NB-1:0]         run,
  output logic [WORD_W-1:0]     rdata_o,
  output logic                  rd_ctrl_o,
  output logic                  rd_unmapped_o
);
  logic [WORD_W-1:0] nxt;
  logic              is_ctrl;
  logic              is_vote;
  logic              rd;

  assign rd = sel & ~we;

  always_comb begin
    nxt     = '0;
    is_ctrl = 1'b0;
    is_vote = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (addr == ADDR_W'(i)) begin
        nxt     = ctrl_word(run[i], fsm[i], en[i]);
        is_ctrl = 1'b1;
      end
    end
    for (int v = 0; v < NV; v++) begin
      if (addr == ADDR_W'(NB + v)) begin
        nxt     = WORD_W'(votes[v]);
        is_vote = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o       <= '0;
      rd_ctrl_o     <= 1'b0;
      rd_unmapped_o <= 1'b0;
    end else begin
      rd_ctrl_o     <= rd & is_ctrl;
      rd_unmapped_o <= rd & ~is_ctrl & ~is_vote;
      if (rd) rdata_o <= nxt;
    end
  end
endmodule

// File: rtl/vclk_branch_gate.sv
module vclk_branch_gate
  import vcbg_pkg::*;
#(
  parameter int unsigned NUM_BRANCH = 4,
  parameter int unsigned NUM_VOTERS = 2,
  parameter int unsigned ON_LAT     = 4,
  parameter int unsigned OFF_LAT    = 2,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [NUM_BRANCH-1:0] clk_en_o
);
  logic [NUM_BRANCH-1:0]                 en_vec;
  logic [NUM_BRANCH-1:0]                 fsm_vec;
  logic [NUM_VOTERS-1:0][NUM_BRANCH-1:0] vote_vec;
  logic [NUM_BRANCH-1:0]                 req_vec;
  logic [NUM_BRANCH-1:0]                 run_vec;
  logic [NUM_BRANCH-1:0]                 start_evt;
  logic [NUM_BRANCH-1:0]                 stop_evt;
  logic                                  rd_ctrl_q;
  logic                                  rd_unmapped_q;

  vcbg_regs #(.NB(NUM_BRANCH), .NV(NUM_VOTERS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .en_o(en_vec), .fsm_o(fsm_vec), .votes_o(vote_vec),
    .req_o(req_vec)
  );

  for (genvar b = 0; b < NUM_BRANCH; b++) begin : g_branch
    vcbg_settle #(.ON_LAT(ON_LAT), .OFF_LAT(OFF_LAT)) u_settle (
      .clk(clk), .rst_n(rst_n), .req(req_vec[b]), .run(run_vec[b]),
      .start_evt(start_evt[b]), .stop_evt(stop_evt[b])
    );
  end

  vcbg_rdmux #(.NB(NUM_BRANCH), .NV(NUM_VOTERS), .ADDR_W(ADDR_W)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .en(en_vec), .fsm(fsm_vec), .votes(vote_vec), .run(run_vec),
    .rdata_o(bus_rdata), .rd_ctrl_o(rd_ctrl_q), .rd_unmapped_o(rd_unmapped_q)
  );

  assign clk_en_o = req_vec;
endmodule

// File: rtl/vcbg_checker.sv
module vcbg_checker #(
  parameter int unsigned NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] req,
  input logic [NB-1:0] run,
  input logic [NB-1:0] start_evt,
  input logic [NB-1:0] stop_evt,
  input logic          rd_ctrl,
  input logic          rd_unmapped,
  input logic [31:0]   rdata
);
  for (genvar b = 0; b < NB; b++) begin : g_chk
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt[b] |=> run[b]);                                   // R3
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt[b] |=> !run[b]);                                   // R5
    AST_SETTLED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req[b] == run[b]) |=> $stable(run[b]));                    // R6
    AST_VOTE_NO_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
      (run[b] && req[b]) |=> run[b]);                             // R7
  end

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> (rdata[31:28] == 4'h0 || rdata[31:28] == 4'h2 || rdata[31:28] == 4'h8)); // R4
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> (rdata[27:2] == '0));                             // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |-> (rdata == 32'h0));                            // R9
endmodule

bind vclk_branch_gate vcbg_checker #(.NB(NUM_BRANCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req_vec), .run(run_vec),
  .start_evt(start_evt), .stop_evt(stop_evt), .rd_ctrl(rd_ctrl_q),
  .rd_unmapped(rd_unmapped_q), .rdata(bus_rdata)
);

// File: tb/tb_vclk_branch_gate.sv
`timescale 1ns/1ps
module tb_vclk_branch_gate;
  localparam int NB = 4, NV = 2, ONL = 4, OFFL = 2, AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wd = '0;
  logic [31:0]   rdata;
  logic [NB-1:0] clk_en;

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  vclk_branch_gate #(.NUM_BRANCH(NB), .NUM_VOTERS(NV), .ON_LAT(ONL),
                     .OFF_LAT(OFFL), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wd), .bus_rdata(rdata), .clk_en_o(clk_en));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_en[NB], m_fsm[NB], m_run[NB], m_cnt[NB], m_vote[NV];
  logic [31:0] m_rd;

  function automatic int m_req(input int b);
    int r;
    r = m_en[b];
    for (int v = 0; v < NV; v++) if ((m_vote[v] >> b) & 1) r = 1;
    return r;
  endfunction

  function automatic logic [31:0] m_word(input int a);
    logic [31:0] w;
    w = 32'h0;
    if (a < NB) begin
      if (m_run[a] == 0) w = 32'h8000_0000;
      else if (m_fsm[a] != 0) w = 32'h2000_0000;
      w = w | (m_fsm[a] != 0 ? 32'h2 : 32'h0) | (m_en[a] != 0 ? 32'h1 : 32'h0);
    end else if (a < NB + NV) w = 32'(m_vote[a - NB]);
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin m_en[b] = 0; m_fsm[b] = 0; m_run[b] = 0; m_cnt[b] = 0; end
      for (int v = 0; v < NV; v++) m_vote[v] = 0;
      m_rd = 32'h0;
    end else begin
      if (sel && !we) m_rd = m_word(int'(addr));
      for (int b = 0; b < NB; b++) begin
        int rq, lim;
        rq = m_req(b);
        if (rq != m_run[b]) begin
          lim = (m_run[b] != 0) ? OFFL : ONL;
          if (m_cnt[b] == lim - 1) begin m_run[b] = rq; m_cnt[b] = 0; end
          else m_cnt[b] = m_cnt[b] + 1;
        end else m_cnt[b] = 0;
      end
      if (sel && we) begin
        int a;
        a = int'(addr);
        if (a < NB) begin m_en[a] = int'(wd[0]); m_fsm[a] = int'(wd[1]); end
        else if (a < NB + NV) m_vote[a - NB] = int'(wd) & ((1 << NB) - 1);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      logic [31:0] e;
      e = 32'h0;
      for (int b = 0; b < NB; b++) e[b] = (m_req(b) != 0);
      check("R2 clk_en model", 32'(clk_en), e);
      check("R9 rdata model", rdata, m_rd);
    end
  end

  // ---------------- bus tasks (entered at a falling edge) ----------------
  task automatic wr(input int a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = AW'(a); wd = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // count polls until the off flag reaches the wanted state
  task automatic poll(input int a, input bit want_on, output int n, output logic [31:0] last);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      rd(a, last);
      if ((last[31] == 1'b0) == want_on) break;
      n++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);

    // R1 reset state
    rd(0, d);  check("R1 ctrl0 reset", d, 32'h8000_0000);
    rd(3, d);  check("R1 ctrl3 reset", d, 32'h8000_0000);
    rd(NB, d); check("R1 vote0 reset", d, 32'h0);
    check("R1 clk_en reset", 32'(clk_en), 32'h0);

    // R2/R3 local enable, start-up latency
    wr(1, 32'h1);
    check("R2 clk_en after enable", 32'(clk_en), 32'h2);
    poll(1, 1, n, d);
    check("R3 off polls", 32'(n), 32'(ONL));
    check("R3 running word", d, 32'h0000_0001);

    // R4 fabric-managed running code
    wr(1, 32'h3);
    rd(1, d); check("R4 fsm running word", d, 32'h2000_0003);

    // R5 stop latency
    wr(1, 32'h0);
    check("R2 clk_en after disable", 32'(clk_en), 32'h0);
    poll(1, 0, n, d);
    check("R5 on polls", 32'(n), 32'(OFFL));
    check("R5 off word", d, 32'h8000_0000);

    // R6 request reverts before latency
    wr(2, 32'h1); idle(1); wr(2, 32'h0);
    for (int k = 0; k < 5; k++) begin rd(2, d); check("R6 no status change", d, 32'h8000_0000); end
    wr(2, 32'h1);
    poll(2, 1, n, d);
    check("R6 restart full latency", 32'(n), 32'(ONL));

    // R7 vote on a running branch
    wr(NB, 32'h4);
    for (int k = 0; k < 5; k++) begin rd(2, d); check("R7 stays running", d, 32'h0000_0001); end
    wr(2, 32'h0);
    for (int k = 0; k < 5; k++) begin rd(2, d); check("R10 vote holds branch", d, 32'h0000_0000); end
    check("R10 clk_en held by vote", 32'(clk_en), 32'h4);

    // R10 independent voters
    wr(NB + 1, 32'h4); wr(NB, 32'h0);
    check("R10 second voter holds", 32'(clk_en), 32'h4);
    rd(2, d); check("R10 still running", d, 32'h0);
    wr(NB + 1, 32'h0);
    check("R10 last vote drops", 32'(clk_en), 32'h0);
    poll(2, 0, n, d);
    check("R5 vote stop polls", 32'(n), 32'(OFFL));

    // R8 ignored bits
    wr(3, 32'hFFFF_FFFC);
    rd(3, d); check("R8 ctrl reserved ignored", d, 32'h8000_0000);
    wr(NB, 32'hFFFF_FFF0);
    rd(NB, d); check("R8 vote high bits ignored", d, 32'h0);
    check("R8 clk_en untouched", 32'(clk_en), 32'h0);

    // R9 unmapped space
    wr(9, 32'hFFFF_FFFF);
    rd(9, d); check("R9 unmapped reads zero", d, 32'h0);
    rd(0, d); check("R9 unmapped write harmless", d, 32'h8000_0000);
    check("R9 clk_en after unmapped write", 32'(clk_en), 32'h0);

    // R2/R3 vote-only start
    wr(NB + 1, 32'h1);
    check("R2 vote-only enable", 32'(clk_en), 32'h1);
    poll(0, 1, n, d);
    check("R3 vote start polls", 32'(n), 32'(ONL));
    check("R3 vote running word", d, 32'h0);

    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule